// File: doc/BRIEF.md
# Up-Counting Interval Timer with Auto-Reload

This block is a general-purpose interval timer. It has a register bus addressed by word and one level interrupt line. A counter, `CNT_W` bits wide and 32 by default, advances by one on each clock edge where the slow tick enable is high and the run bit is set. When the counter steps past the all-ones value, the timer either reloads a programmed start value (auto-reload) or wraps to zero and stops (one-shot). In both cases it records an overflow event. A compare register can also record a match event. Because the counter runs upward, software sets a period of N+1 ticks by writing all-ones minus N into both the load register and the counter.

Events latch into a status register. Software clears a status bit by writing 1 to it. Each event has an enable bit. The enables are turned on through a set register and turned off through a clear register, each of which takes a bit mask. The interrupt output is high while any pending event has its enable on.

The register bus is a control path, not a data stream. It has no valid/ready pair and never applies back-pressure. A write is taken on every clock edge where `reg_wr` is high. `reg_rdata` shows the register at `reg_addr` combinationally, from the state present at that moment.

Top module: `gpt_timer`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is low.
- R2: Control register fields are bit 0 = run, bit 1 = auto-reload, bit 6 = compare enable. On each edge with run = 1 and `tick_en` = 1, the counter (address 1) increases by 1. Without a tick, or with run = 0, the counter holds its value. Writing the control register with run = 0 freezes the counter where it is.
- R3: If the counter is at all-ones on a counting edge and auto-reload is on, the next counter value is the load register (address 2). Status bit 1 (overflow) is set. So with load L, overflows come every 2^CNT_W − L ticks.
- R4: If the counter is at all-ones on a counting edge and auto-reload is off, the counter becomes 0, the run bit clears, and status bit 1 is set. The counter then stays still while ticks keep arriving.
- R5: With compare enable on, a counting edge on which the counter equals the match register (address 3) sets status bit 0 (match). With compare enable off, no match event is raised.
- R6: A write to address 1 loads the counter directly. It takes precedence over a tick on the same edge.
- R7: Writing status (address 4) clears each bit whose data bit is 1 and leaves bits written with 0 unchanged. An event on the same edge as its clear leaves the bit set.
- R8: Writing a mask to address 5 turns those enables on. Writing a mask to address 6 turns them off. Addresses 5, 6 and 7 all read back the enable bits, with bit 0 = match and bit 1 = overflow.
- R9: `irq_o` is high exactly while some status bit and its enable bit are both 1. It stays high until that bit is cleared or disabled.
- R10: Load (address 2) and match (address 3) read back what was last written. The control register reads back only bits 0, 1 and 6. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Slow tick; the counter advances on clock edges where this is high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address of the register |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for `reg_addr` (combinational) |
| irq_o | output | 1 | Level interrupt: OR of pending events that are enabled |

## Verification
The bench builds the timer with the default 32-bit counter. Most writes to the load, counter and match registers place values a few hundred counts below all-ones. This puts overflow, reload, one-shot stop and compare hits within a few thousand cycles even at full width, and it also exercises the top bit of the width. Random control, status and enable writes land on the same edges as ticks and events. This reaches the cases where a counter write overrides a tick, where a clear meets a new event, and where a control write meets a one-shot stop.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT   = 3'd1;
  localparam logic [ADDR_W-1:0] A_LOAD  = 3'd2;
  localparam logic [ADDR_W-1:0] A_MATCH = 3'd3;
  localparam logic [ADDR_W-1:0] A_STS   = 3'd4;
  localparam logic [ADDR_W-1:0] A_ESET  = 3'd5;
  localparam logic [ADDR_W-1:0] A_ECLR  = 3'd6;
  localparam logic [ADDR_W-1:0] A_ENA   = 3'd7;

  localparam int B_RUN  = 0;
  localparam int B_AUTO = 1;
  localparam int B_CMP  = 6;

  localparam int EV_MATCH = 0;
  localparam int EV_OVF   = 1;
  localparam int NEV      = 2;
endpackage

// File: rtl/gpt_count_core.sv
module gpt_count_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             wr_ctrl,
  input  logic             run_wd,
  input  logic             wr_cnt,
  input  logic [CNT_W-1:0] cnt_wd,
  input  logic             auto_rl,
  input  logic             cmp_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] match_val,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             ovf_evt,
  output logic             match_evt
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             step;
  logic             at_top;

  assign step      = run_q && tick_en;
  assign at_top    = (cnt_q == '1);
  assign ovf_evt   = step && at_top;
  assign match_evt = step && cmp_en && (cnt_q == match_val);

  // counter: software write wins, then tick
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (wr_cnt) begin
      cnt_q <= cnt_wd;
    end else if (step) begin
      if (at_top) cnt_q <= auto_rl ? load_val : '0;
      else        cnt_q <= cnt_q + ONE;
    end
  end

  // run bit: control write wins, else one-shot stops at overflow
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
    end else if (wr_ctrl) begin
      run_q <= run_wd;
    end else if (ovf_evt && !auto_rl) begin
      run_q <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;
  assign run_o = run_q;
endmodule

// File: rtl/gpt_irq_unit.sv
module gpt_irq_unit #(
  parameter int NEV = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] evt,
  input  logic           wr_sts,
  input  logic           wr_set,
  input  logic           wr_clr,
  input  logic [NEV-1:0] mask,
  output logic [NEV-1:0] sts_o,
  output logic [NEV-1:0] ena_o,
  output logic           irq_o
);
  logic [NEV-1:0] sts_q;
  logic [NEV-1:0] ena_q;

  for (genvar k = 0; k < NEV; k++) begin : g_ev
    // status: event beats write-one-to-clear
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   sts_q[k] <= 1'b0;
      else if (evt[k])              sts_q[k] <= 1'b1;
      else if (wr_sts && mask[k])   sts_q[k] <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   ena_q[k] <= 1'b0;
      else if (wr_set && mask[k])   ena_q[k] <= 1'b1;
      else if (wr_clr && mask[k])   ena_q[k] <= 1'b0;
    end
  end

  assign sts_o = sts_q;
  assign ena_o = ena_q;
  assign irq_o = |(sts_q & ena_q);
endmodule

// File: rtl/gpt_timer.sv
module gpt_timer
  import gpt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic              irq_o
);
  logic             wr_ctrl, wr_cnt, wr_load, wr_match, wr_sts, wr_set, wr_clr;
  logic             auto_q, cmp_q;
  logic [CNT_W-1:0] load_q, match_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             ovf_evt, match_evt;
  logic [NEV-1:0]   evt, sts_q, ena_q;
  logic [CNT_W-1:0] ctrl_rd;

  assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
  assign wr_cnt   = reg_wr && (reg_addr == A_CNT);
  assign wr_load  = reg_wr && (reg_addr == A_LOAD);
  assign wr_match = reg_wr && (reg_addr == A_MATCH);
  assign wr_sts   = reg_wr && (reg_addr == A_STS);
  assign wr_set   = reg_wr && (reg_addr == A_ESET);
  assign wr_clr   = reg_wr && (reg_addr == A_ECLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_q  <= 1'b0;
      cmp_q   <= 1'b0;
      load_q  <= '0;
      match_q <= '0;
    end else begin
      if (wr_ctrl) begin
        auto_q <= reg_wdata[B_AUTO];
        cmp_q  <= reg_wdata[B_CMP];
      end
      if (wr_load)  load_q  <= reg_wdata;
      if (wr_match) match_q <= reg_wdata;
    end
  end

  gpt_count_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .wr_ctrl   (wr_ctrl),
    .run_wd    (reg_wdata[B_RUN]),
    .wr_cnt    (wr_cnt),
    .cnt_wd    (reg_wdata),
    .auto_rl   (auto_q),
    .cmp_en    (cmp_q),
    .load_val  (load_q),
    .match_val (match_q),
    .cnt_o     (cnt_q),
    .run_o     (run_q),
    .ovf_evt   (ovf_evt),
    .match_evt (match_evt)
  );

  always_comb begin
    evt           = '0;
    evt[EV_MATCH] = match_evt;
    evt[EV_OVF]   = ovf_evt;
  end

  gpt_irq_unit #(.NEV(NEV)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (evt),
    .wr_sts (wr_sts),
    .wr_set (wr_set),
    .wr_clr (wr_clr),
    .mask   (reg_wdata[NEV-1:0]),
    .sts_o  (sts_q),
    .ena_o  (ena_q),
    .irq_o  (irq_o)
  );

  always_comb begin
    ctrl_rd         = '0;
    ctrl_rd[B_RUN]  = run_q;
    ctrl_rd[B_AUTO] = auto_q;
    ctrl_rd[B_CMP]  = cmp_q;
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = ctrl_rd;
      A_CNT:   reg_rdata = cnt_q;
      A_LOAD:  reg_rdata = load_q;
      A_MATCH: reg_rdata = match_q;
      A_STS:   reg_rdata = {{(CNT_W-NEV){1'b0}}, sts_q};
      default: reg_rdata = {{(CNT_W-NEV){1'b0}}, ena_q};
    endcase
  end
endmodule

// File: rtl/gpt_timer_chk.sv
module gpt_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             reg_wr,
  input logic [2:0]       reg_addr,
  input logic [CNT_W-1:0] reg_wdata,
  input logic [CNT_W-1:0] cnt,
  input logic             running,
  input logic             auto_rl,
  input logic [CNT_W-1:0] load,
  input logic [1:0]       sts,
  input logic [1:0]       ena,
  input logic             irq
);
  logic ctrl_or_cnt_wr;
  assign ctrl_or_cnt_wr = reg_wr && (reg_addr == 3'd0 || reg_addr == 3'd1);

  // R2: one step per counting edge below the top value
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    running && tick_en && !ctrl_or_cnt_wr && cnt != '1
    |=> cnt == $past(cnt) + 1'b1);

  // R2: a stopped counter holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !running && !ctrl_or_cnt_wr |=> $stable(cnt) && !running);

  // R3: reload at the top with auto-reload
  a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
    running && auto_rl && tick_en && cnt == '1 && !ctrl_or_cnt_wr
    |=> cnt == $past(load) && sts[1]);

  // R4: one-shot stops at zero
  a_r4_oneshot: assert property (@(posedge clk) disable iff (!rst_n)
    running && !auto_rl && tick_en && cnt == '1 && !ctrl_or_cnt_wr
    |=> cnt == '0 && !running && sts[1]);

  // R7: overflow status stays until cleared by a one
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    sts[1] && !(reg_wr && reg_addr == 3'd4 && reg_wdata[1]) |=> sts[1]);

  // R8: set register turns on the enable
  a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 3'd5 && reg_wdata[0] |=> ena[0]);

  // R9: interrupt level persists without a clear or disable
  a_r9_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !(reg_wr && (reg_addr == 3'd4 || reg_addr == 3'd6)) |=> irq);
endmodule

bind gpt_timer gpt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .cnt       (cnt_q),
  .running   (run_q),
  .auto_rl   (auto_q),
  .load      (load_q),
  .sts       (sts_q),
  .ena       (ena_q),
  .irq       (irq_o)
);

// File: tb/gpt_timer_tb.sv
module gpt_timer_tb;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick_en = 1'b0;
  logic         reg_wr = 1'b0;
  logic [2:0]   reg_addr = 3'd0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic         irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  gpt_timer #(.CNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o)
  );

  // reference state, derived from the requirements
  logic [W-1:0] m_cnt, m_load, m_match;
  logic         m_run, m_auto, m_cmp;
  logic [1:0]   m_sts, m_ena;

  function automatic logic [W-1:0] m_read(input logic [2:0] a);
    logic [W-1:0] v;
    v = '0;
    case (a)
      3'd0: begin v[0] = m_run; v[1] = m_auto; v[6] = m_cmp; end
      3'd1: v = m_cnt;
      3'd2: v = m_load;
      3'd3: v = m_match;
      3'd4: v[1:0] = m_sts;
      default: v[1:0] = m_ena;
    endcase
    return v;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = '0; m_load = '0; m_match = '0;
    m_run = 0; m_auto = 0; m_cmp = 0; m_sts = '0; m_ena = '0;
  endtask

  // one clock: drive at negedge, advance model, check after the edge
  task automatic step(input string tag, input logic tk, input logic wr,
                      input logic [2:0] a, input logic [W-1:0] wd);
    logic se, top, ovf, mev;
    logic [W-1:0] n_cnt;
    logic n_run;
    @(negedge clk);
    tick_en = tk; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    se  = m_run && tk;
    top = (m_cnt == '1);
    ovf = se && top;
    mev = se && m_cmp && (m_cnt == m_match);
    if (wr && a == 3'd1) n_cnt = wd;
    else if (se)         n_cnt = top ? (m_auto ? m_load : '0) : m_cnt + 1;
    else                 n_cnt = m_cnt;
    if (wr && a == 3'd0) n_run = wd[0];
    else if (ovf && !m_auto) n_run = 1'b0;
    else n_run = m_run;
    @(posedge clk);
    m_cnt = n_cnt;
    m_run = n_run;
    if (wr && a == 3'd0) begin m_auto = wd[1]; m_cmp = wd[6]; end
    if (wr && a == 3'd2) m_load = wd;
    if (wr && a == 3'd3) m_match = wd;
    m_sts[1] = ovf | (m_sts[1] & ~(wr && a == 3'd4 && wd[1]));
    m_sts[0] = mev | (m_sts[0] & ~(wr && a == 3'd4 && wd[0]));
    if (wr && a == 3'd5) m_ena = m_ena | wd[1:0];
    if (wr && a == 3'd6) m_ena = m_ena & ~wd[1:0];
    #1;
    check(tag, reg_rdata, m_read(a));
    check({tag, " R9 irq"}, {{(W-1){1'b0}}, irq_o}, {{(W-1){1'b0}}, |(m_sts & m_ena)});
  endtask

  task automatic rd(input string tag, input logic [2:0] a);
    step(tag, 1'b0, 1'b0, a, '0);
  endtask

  task automatic wr(input string tag, input logic [2:0] a, input logic [W-1:0] d);
    step(tag, 1'b0, 1'b1, a, d);
  endtask

  task automatic ticks(input string tag, input int n, input logic [2:0] a);
    for (int i = 0; i < n; i++) step(tag, 1'b1, 1'b0, a, '0);
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset values
    #1 check("R1 irq", {{(W-1){1'b0}}, irq_o}, '0);
    for (int a = 0; a < 8; a++) rd("R1 reset", 3'(a));

    // R10: readback of load, match, control mask
    wr("R10 load", 3'd2, 32'hA5A5_0001); rd("R10 load", 3'd2);
    wr("R10 match", 3'd3, 32'h5A5A_1234); rd("R10 match", 3'd3);
    wr("R10 ctrl", 3'd0, 32'hFFFF_FFBE); rd("R10 ctrl", 3'd0);
    wr("R10 ctrl", 3'd0, 32'h0);

    // R2: counting, no tick, freeze
    wr("R6 cnt", 3'd1, 32'd100);
    wr("R2 run", 3'd0, 32'h1);
    ticks("R2 count", 5, 3'd1);
    for (int i = 0; i < 3; i++) rd("R2 no tick", 3'd1);
    wr("R2 freeze", 3'd0, 32'h0);
    ticks("R2 frozen", 4, 3'd1);

    // R6: counter write beats tick
    wr("R2 run", 3'd0, 32'h1);
    step("R6 wr vs tick", 1'b1, 1'b1, 3'd1, 32'h0000_0777);
    rd("R6 wr vs tick", 3'd1);

    // R8 / R3: auto-reload overflow with interrupt
    wr("R8 set", 3'd5, 32'h3); rd("R8 ena rd", 3'd7); rd("R8 ena rd", 3'd6);
    wr("R3 load", 3'd2, 32'hFFFF_FFF0);
    wr("R3 cnt", 3'd1, 32'hFFFF_FFFE);
    wr("R3 ctrl", 3'd0, 32'h3);
    ticks("R3 reload", 2, 3'd1);
    rd("R3 status", 3'd4);
    ticks("R3 period", 16, 3'd4);
    rd("R3 cnt", 3'd1);

    // R7: clear with zero then one, and clear vs event on the same edge
    wr("R7 no clear", 3'd4, 32'h0);
    wr("R7 clear", 3'd4, 32'h3);
    wr("R7 cnt", 3'd1, 32'hFFFF_FFFF);
    step("R7 evt vs clear", 1'b1, 1'b1, 3'd4, 32'h2);
    rd("R7 held", 3'd4);

    // R8: clear register drops the enable, irq falls
    wr("R8 clr", 3'd6, 32'h2); rd("R8 ena", 3'd5);
    wr("R7 clear all", 3'd4, 32'h7);

    // R4: one-shot
    wr("R4 cnt", 3'd1, 32'hFFFF_FFFD);
    wr("R4 ctrl", 3'd0, 32'h1);
    ticks("R4 oneshot", 3, 3'd1);
    rd("R4 ctrl", 3'd0);
    ticks("R4 stopped", 5, 3'd1);
    rd("R4 status", 3'd4);

    // R5: match with compare on and off
    wr("R5 clr", 3'd4, 32'h3);
    wr("R5 match", 3'd3, 32'd20);
    wr("R5 cnt", 3'd1, 32'd17);
    wr("R5 ctrl", 3'd0, 32'h41);
    ticks("R5 match on", 5, 3'd4);
    wr("R5 clr", 3'd4, 32'h3);
    wr("R5 cnt", 3'd1, 32'd17);
    wr("R5 ctrl", 3'd0, 32'h01);
    ticks("R5 match off", 5, 3'd4);

    // random phase
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] a;
      logic [W-1:0] d;
      logic w;
      w = ($urandom % 8) == 0;
      a = 3'($urandom % 8);
      d = $urandom;
      if (a >= 3'd1 && a <= 3'd3) d = 32'hFFFF_FE00 | (d & 32'h1FF);
      if (!w) a = 3'($urandom % 2 == 0 ? 1 : $urandom % 8);
      step("R2 R3 R4 R5 R7 R8 random", 1'($urandom % 4 != 0), w, a, d);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule